// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block is a bus master that moves one operand of 1 to 4 bytes to or from any byte address. It does not need to know the width of the target port in advance. It opens a bus cycle by driving the address, a code for the number of bytes still to move, and the write data on all four byte lanes. It then waits for an acknowledge. The acknowledge also reports whether the responding port is 8, 16 or 32 bits wide. From that width and the current address offset, the sequencer works out how many bytes the port took. It advances the address and the outstanding count, and opens another cycle until no bytes remain.

Operands are handed over right-justified. The byte that belongs at the lowest address is the most significant byte of the operand. A read operand is returned the same way, and a one-cycle done pulse marks the end of every operation. A new request is accepted only while the sequencer is idle.

Top module: `dbs_seq`

## Requirements
- R1: After reset the sequencer is idle: `req_ready` is 1, `bus_as` is 0 and `done` is 0.
- R2: During every bus cycle `bus_siz` shows the bytes still outstanding, including the bytes of that cycle: 2'b01 = 1, 2'b10 = 2, 2'b11 = 3, 2'b00 = 4. `req_size` uses the same code.
- R3: The acknowledge `bus_ack` means 2'b11 = 32-bit port, 2'b10 = 16-bit port, 2'b01 = 8-bit port, and 2'b00 = no acknowledge. On an acknowledge the bytes taken equal the smaller of two values: the bytes outstanding, and the port width in bytes minus (address mod port width). The next cycle's address and outstanding count advance by that amount.
- R4: `bus_as`, `bus_addr` and `bus_siz` hold steady until an acknowledge is accepted. An acknowledge is ignored in the first clock of every bus cycle, so each cycle has at least one wait state.
- R5: A 4-byte operand at byte offset 1 on a 16-bit port takes exactly three cycles: (siz 00, low address 001), then (11, 010), then (01, 100).
- R6: A 4-byte operand at offset 0 on a 32-bit port completes in one cycle.
- R7: A 2-byte write to an 8-bit port takes two single-byte cycles at consecutive addresses.
- R8: Lane 0 is `bus_wdata[31:24]` and lane 3 is `bus_wdata[7:0]`. An 8-bit port samples lane 0. A 16-bit port samples lanes 0 and 1, using lane (address mod 2) onward. A 32-bit port uses lane (address mod 4) onward. On a write, the next unsent operand byte and the bytes that follow it appear on the lanes that any of these ports samples.
- R9: `done` pulses high for exactly one clock, in the cycle after the final acknowledge. For a read, `rd_data` at that point holds the operand right-justified, with the lowest-address byte most significant. The bytes are gathered from the lanes given in R8.
- R10: A request is taken only while `req_ready` is 1. `req_valid` raised during an operation is ignored and starts no further bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request strobe |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code (R2 encoding) |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | 32 | Write operand, right-justified |
| rd_data | output | 32 | Read operand, right-justified |
| done | output | 1 | One-clock completion pulse |
| bus_as | output | 1 | Address strobe, high for the whole operation |
| bus_rw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_siz | output | 2 | Outstanding byte count code |
| bus_addr | output | ADDR_W | Current byte address |
| bus_wdata | output | 32 | Steered write lanes |
| bus_rdata | input | 32 | Read lanes from the port |
| bus_ack | input | 2 | Acknowledge with port width |

## Verification
The bench builds the sequencer with its default 32-bit address. Its sweep therefore runs operations whose later cycles carry the address into the next 32-bit word, for example from offset 3 into offset 4. Every size is tried at every byte offset, as reads and writes, against ports of all three widths. A behavioural split model checks each bus cycle's strobe, size code and address on every clock. The bench also presents early acknowledges and stray requests to exercise R4 and R10.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = LANES * 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_e;

  // Port width in bytes from the acknowledge code, 0 when no acknowledge.
  function automatic logic [2:0] ack_bytes(input logic [1:0] ack);
    case (ack)
      2'b11:   return 3'd4;
      2'b10:   return 3'd2;
      2'b01:   return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // Size code to byte count (00 means four).
  function automatic logic [2:0] code_count(input logic [1:0] code);
    return (code == 2'b00) ? 3'd4 : {1'b0, code};
  endfunction
endpackage

// File: rtl/dbs_take.sv
module dbs_take
  import dbs_pkg::*;
(
  input  logic [2:0] rem,
  input  logic [1:0] off,
  input  logic [1:0] ack,
  output logic [2:0] take,
  output logic [1:0] lane_off,
  output logic       hit
);
  logic [2:0] width;
  logic [1:0] mask;
  logic [2:0] room;

  always_comb begin
    width    = ack_bytes(ack);
    hit      = (width != 3'd0);
    mask     = width[1:0] - 2'd1;
    lane_off = off & mask;
    room     = width - {1'b0, lane_off};
    if (!hit)            take = 3'd0;
    else if (rem < room) take = rem;
    else                 take = room;
  end
endmodule

// File: rtl/dbs_wsteer.sv
module dbs_wsteer
  import dbs_pkg::*;
(
  input  logic [DATA_W-1:0] opnd,
  input  logic [1:0]        k,
  input  logic [1:0]        a,
  output logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] shifted;

  // Next unsent operand byte moved to the top.
  assign shifted = opnd << {k, 3'b000};

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [1:0]        rel;
    logic [DATA_W-1:0] pick;
    logic [7:0]        lane_b;
    always_comb begin
      if (2'(j) >= a)                  rel = 2'(j) - a;
      else if (2'(j) >= {1'b0, a[0]})  rel = 2'(j) - {1'b0, a[0]};
      else                             rel = 2'd0;
      pick   = shifted << {rel, 3'b000};
      lane_b = pick[DATA_W-1 -: 8];
    end
    assign wdata[DATA_W-1-8*j -: 8] = lane_b;
  end
endmodule

// File: rtl/dbs_rcollect.sv
module dbs_rcollect
  import dbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic [1:0]        k,
  input  logic [2:0]        take,
  input  logic [1:0]        lane_off,
  input  logic [2:0]        size,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] asm_q;

  for (genvar p = 0; p < LANES; p++) begin : g_byte
    logic              hit;
    logic [1:0]        src;
    logic [DATA_W-1:0] sh;
    logic [7:0]        byte_d;
    logic [7:0]        byte_q;
    always_comb begin
      hit    = cap && (3'(p) >= {1'b0, k}) && (3'(p) < ({1'b0, k} + take));
      src    = lane_off + 2'(p) - k;
      sh     = rdata << {src, 3'b000};
      byte_d = sh[DATA_W-1 -: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   byte_q <= 8'h00;
      else if (clr) byte_q <= 8'h00;
      else if (hit) byte_q <= byte_d;
    end
    assign asm_q[DATA_W-1-8*p -: 8] = byte_q;
  end

  assign rd_data = asm_q >> {(3'd4 - size), 3'b000};
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  output logic              done,
  output logic              bus_as,
  output logic              bus_rw,
  output logic [1:0]        bus_siz,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic [1:0]        bus_ack
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [2:0]        rem_q, rem_d;
  logic [2:0]        size_q, size_d;
  logic [1:0]        k_q, k_d;
  logic              wr_q, wr_d;
  logic [31:0]       opnd_q, opnd_d;
  logic              done_q;
  logic              dp_en;

  logic              start, ack_acc, last;
  logic [2:0]        take, cnt;
  logic [1:0]        lane_off;
  logic              hit;

  dbs_take u_take (
    .rem      (rem_q),
    .off      (addr_q[1:0]),
    .ack      (bus_ack),
    .take     (take),
    .lane_off (lane_off),
    .hit      (hit)
  );

  dbs_wsteer u_wsteer (
    .opnd  (opnd_q),
    .k     (k_q),
    .a     (addr_q[1:0]),
    .wdata (bus_wdata)
  );

  dbs_rcollect u_rcol (
    .clk      (clk),
    .rst_n    (rst_s),
    .clr      (start),
    .cap      (ack_acc && !wr_q),
    .k        (k_q),
    .take     (take),
    .lane_off (lane_off),
    .size     (size_q),
    .rdata    (bus_rdata),
    .rd_data  (rd_data)
  );

  // Next state
  always_comb begin
    cnt     = code_count(req_size);
    start   = (st_q == ST_IDLE) && req_valid;
    ack_acc = (st_q == ST_WAIT) && hit;
    last    = ack_acc && (take == rem_q);
    st_d    = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_WAIT;
      ST_WAIT: if (ack_acc) st_d = last ? ST_IDLE : ST_ADDR;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    dp_en  = start || ack_acc;
    addr_d = addr_q;
    rem_d  = rem_q;
    size_d = size_q;
    k_d    = k_q;
    wr_d   = wr_q;
    opnd_d = opnd_q;
    if (start) begin
      addr_d = req_addr;
      rem_d  = cnt;
      size_d = cnt;
      k_d    = 2'd0;
      wr_d   = req_write;
      opnd_d = req_wdata << {(3'd4 - cnt), 3'b000};
    end else if (ack_acc) begin
      addr_d = addr_q + ADDR_W'(take);
      rem_d  = rem_q - take;
      k_d    = k_q + take[1:0];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= last;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      addr_q <= '0;
      rem_q  <= 3'd0;
      size_q <= 3'd4;
      k_q    <= 2'd0;
      wr_q   <= 1'b0;
      opnd_q <= '0;
    end else if (dp_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      size_q <= size_d;
      k_q    <= k_d;
      wr_q   <= wr_d;
      opnd_q <= opnd_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign bus_as    = (st_q != ST_IDLE);
  assign bus_rw    = !wr_q;
  assign bus_siz   = rem_q[1:0];
  assign bus_addr  = addr_q;
  assign done      = done_q;

  // Assertions
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_as && !ack_acc) |=> (bus_as && $stable(bus_addr) && $stable(bus_siz))); // R4
  AST_FIRST_CLK_WAITS: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_ADDR) |=> (st_q == ST_WAIT && $stable(bus_addr))); // R4
  AST_TAKE_RANGE: assert property (@(posedge clk) disable iff (!rst_s)
    ack_acc |-> (take != 3'd0 && take <= rem_q)); // R3
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_s)
    (ack_acc && !last) |=> (bus_as && rem_q == $past(rem_q) - $past(take)
                            && bus_addr == $past(bus_addr) + ADDR_W'($past(take)))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (!bus_as && req_ready)); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    req_ready |-> !bus_as); // R10
endmodule

// File: tb/tb_dbs_seq.sv
module tb_dbs_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata, rd_data;
  logic        done, bus_as, bus_rw;
  logic [1:0]  bus_siz, bus_ack;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  dbs_seq #(.ADDR_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .bus_as(bus_as),
    .bus_rw(bus_rw), .bus_siz(bus_siz), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] memb(input logic [31:0] a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  // Behavioural model: split the operand, then follow the bus clock by clock.
  task automatic run_op(input bit wr, input int size, input logic [31:0] addr,
                        input logic [31:0] wdat, input logic [1:0] ack,
                        input int lat, input bit early, input bit poke,
                        input string tag);
    int          pw;
    int          ea[$];
    int          en[$];
    int          er[$];
    int          rem;
    logic [31:0] a;
    logic [7:0]  opb [8];
    logic [31:0] exp_rd;
    int          k;
    pw  = (ack == 2'b11) ? 4 : (ack == 2'b10) ? 2 : 1;
    rem = size;
    a   = addr;
    while (rem > 0) begin
      int room;
      int n;
      room = pw - int'(a % pw);
      n    = (rem < room) ? rem : room;
      ea.push_back(int'(a)); en.push_back(n); er.push_back(rem);
      a   = a + n;
      rem = rem - n;
    end
    for (int i = 0; i < 8; i++) opb[i] = 8'h00;
    for (int i = 0; i < size; i++) opb[i] = wdat[8*(size-1-i) +: 8];
    req_valid = 1'b1; req_write = wr; req_size = 2'(size);
    req_addr = addr; req_wdata = wdat;
    @(posedge clk); @(negedge clk);
    k = 0;
    for (int c = 0; c < ea.size(); c++) begin
      for (int w = 0; w <= lat; w++) begin
        req_valid = 1'b0;
        chk(bus_as === 1'b1, {tag, " R4 strobe held"}, 32'(bus_as), 32'd1);
        chk(bus_siz === 2'(er[c]), {tag, " R2 size code"}, 32'(bus_siz), 32'(er[c]));
        chk(bus_addr === 32'(ea[c]), {tag, " R3 address"}, bus_addr, 32'(ea[c]));
        chk(bus_rw === !wr, {tag, " R3 direction"}, 32'(bus_rw), 32'(!wr));
        if (poke && c == 0 && w == 0) begin
          req_valid = 1'b1; req_addr = addr + 32'd100;
          chk(req_ready === 1'b0, {tag, " R10 busy"}, 32'(req_ready), 32'd0);
        end
        bus_ack   = (w == lat || (early && w == 0)) ? ack : 2'b00;
        bus_rdata = 32'hEEEE_EEEE;
        if (w == lat) begin
          int off;
          off = ea[c] % pw;
          for (int i = 0; i < en[c]; i++) begin
            bus_rdata[31-8*(off+i) -: 8] = memb(32'(ea[c] + i));
            if (wr)
              chk(bus_wdata[31-8*(off+i) -: 8] === opb[k+i], {tag, " R8 write lane"},
                  32'(bus_wdata[31-8*(off+i) -: 8]), 32'(opb[k+i]));
          end
          k = k + en[c];
        end
        @(posedge clk); @(negedge clk);
      end
    end
    bus_ack = 2'b00; req_valid = 1'b0;
    chk(done === 1'b1, {tag, " R9 done after last ack"}, 32'(done), 32'd1);
    chk(bus_as === 1'b0, {tag, " R3 cycle count"}, 32'(bus_as), 32'd0);
    if (!wr) begin
      exp_rd = 32'd0;
      for (int i = 0; i < size; i++) exp_rd = (exp_rd << 8) | 32'(memb(addr + 32'(i)));
      chk(rd_data === exp_rd, {tag, " R9 read data"}, rd_data, exp_rd);
    end
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0, {tag, " R9 single pulse"}, 32'(done), 32'd0);
    chk(bus_as === 1'b0, {tag, " R10 no restart"}, 32'(bus_as), 32'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b00;
    req_addr = '0; req_wdata = '0; bus_ack = 2'b00; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(bus_as === 1'b0, "R1 strobe", 32'(bus_as), 32'd0);
    chk(done === 1'b0, "R1 done", 32'(done), 32'd0);

    run_op(1'b1, 4, 32'h0000_1001, 32'h1122_3344, 2'b10, 1, 1'b0, 1'b0, "R5 long odd 16b");
    run_op(1'b1, 4, 32'h0000_2000, 32'hCAFE_F00D, 2'b11, 1, 1'b0, 1'b0, "R6 aligned 32b");
    run_op(1'b1, 2, 32'h0000_3000, 32'h0000_BEEF, 2'b01, 2, 1'b0, 1'b0, "R7 word on 8b");
    run_op(1'b0, 4, 32'h0000_1003, 32'h0, 2'b11, 1, 1'b0, 1'b0, "R9 read 32b");
    run_op(1'b0, 3, 32'h0000_0102, 32'h0, 2'b10, 3, 1'b0, 1'b0, "R9 read 16b");
    run_op(1'b1, 3, 32'h0000_0041, 32'h00A5_5A77, 2'b11, 2, 1'b1, 1'b0, "R4 early ack");
    run_op(1'b0, 2, 32'h0000_0777, 32'h0, 2'b01, 1, 1'b1, 1'b1, "R10 stray request");

    for (int wr = 0; wr < 2; wr++)
      for (int sz = 1; sz <= 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int ak = 1; ak <= 3; ak++)
            run_op(wr[0], sz, 32'h0000_0500 + 32'(16 * sz + off),
                   32'h9A3C_5E71 ^ 32'(sz * 977 + off * 31 + ak),
                   2'(ak), 1 + (off % 2), 1'b0, 1'b0, "R3 sweep");

    finish_run();
  end
endmodule